// File: doc/BRIEF.md
# Conditional Execution Flag Unit

This block keeps the four arithmetic status flags of a processor pipeline (negative, zero, carry, overflow) and decides, for every issued instruction, whether that instruction is allowed to take effect. Each instruction presents a 4-bit condition code. The unit evaluates that code against the flags already held in its register and raises an execute-enable. The rest of the pipeline uses that enable to suppress register writes and memory side effects. An instruction whose condition fails still occupies its issue slot for one cycle, but it leaves no trace.

When an instruction executes, the flag register may load the ALU's N/Z/C/V results. This happens when the instruction asks for a flag update, or when it belongs to the compare/test class, whose only purpose is to set flags. A separate write port lets a status-register move replace the four flags directly, without disturbing any other status bits held elsewhere.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst_n` is low, and at the first cycle after it rises, `flags_q` reads 0000. The flag vector is packed as {N, Z, C, V}, with N in bit 3 and V in bit 0.
- R2: With `instr_valid` high, codes 0..7 give `exec_en` equal to the following single-flag tests:
  - 0: Z = 1
  - 1: Z = 0
  - 2: C = 1
  - 3: C = 0
  - 4: N = 1
  - 5: N = 0
  - 6: V = 1
  - 7: V = 0
- R3: Code 8 (unsigned higher) passes when C = 1 and Z = 0. Code 9 (unsigned lower-or-same) passes when C = 0 or Z = 1.
- R4: The signed codes pass as follows:
  - Code 10 passes when N = V.
  - Code 11 passes when N ≠ V.
  - Code 12 passes when Z = 0 and N = V.
  - Code 13 passes when Z = 1 or N ≠ V.
- R5: Code 14 always passes. Code 15 never passes.
- R6: An executing instruction with `set_flags` high loads `alu_flags` into `flags_q` at the next clock edge.
- R7: An executing instruction with `cmp_class` high loads `alu_flags` at the next edge even when `set_flags` is low.
- R8: An instruction whose condition fails leaves `flags_q` unchanged, whatever its `set_flags` and `cmp_class` are.
- R9: An executing instruction with both `set_flags` and `cmp_class` low leaves `flags_q` unchanged.
- R10: When `flag_wr_en` is high, `flags_q` takes `flag_wr_data` at the next edge. This write has priority over any ALU flag update in the same cycle.
- R11: `exec_en` is evaluated against the flags registered before the current instruction. A flag update made by an instruction first affects the condition of the following instruction.
- R12: With `instr_valid` low, `exec_en` is 0 and the ALU results do not reach `flags_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears the flags |
| instr_valid | input | 1 | An instruction occupies the slot this cycle |
| cond_code | input | 4 | Condition field of the instruction |
| alu_flags | input | 4 | ALU result flags {N, Z, C, V} |
| set_flags | input | 1 | Instruction requests a flag update |
| cmp_class | input | 1 | Instruction is a compare or test operation |
| flag_wr_en | input | 1 | Direct write of the four flags |
| flag_wr_data | input | 4 | Value for the direct write {N, Z, C, V} |
| exec_en | output | 1 | Instruction executes this cycle |
| flags_q | output | 4 | Registered flags {N, Z, C, V} |

## Verification
The assertions assume the inputs settle before each rising edge and stay free of X while reset is high. They also assume that `alu_flags` describes the instruction presented in the same cycle. The bench drives every input on the falling edge, so the stimulus always meets these assumptions. It sweeps all sixteen condition codes against all sixteen flag states, loading each flag state through the write port. It then mixes random update, compare, failing and idle slots, including cycles where the write port and an ALU update collide.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
    localparam int FLAG_W = 4;
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FC = 1;
    localparam int FV = 0;

    typedef enum logic [3:0] {
        CC_ZSET  = 4'd0,
        CC_ZCLR  = 4'd1,
        CC_CSET  = 4'd2,
        CC_CCLR  = 4'd3,
        CC_NSET  = 4'd4,
        CC_NCLR  = 4'd5,
        CC_VSET  = 4'd6,
        CC_VCLR  = 4'd7,
        CC_UGT   = 4'd8,
        CC_ULE   = 4'd9,
        CC_SGE   = 4'd10,
        CC_SLT   = 4'd11,
        CC_SGT   = 4'd12,
        CC_SLE   = 4'd13,
        CC_ALL   = 4'd14,
        CC_NONE  = 4'd15
    } cond_e;

    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_ALU   = 2'd1,
        SRC_WRITE = 2'd2
    } flag_src_e;
endpackage

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
    import cfu_pkg::*;
(
    input  cond_e              code,
    input  logic [FLAG_W-1:0]  flags,
    output logic               pass
);
    logic n, z, c, v;

    always_comb begin
        n = flags[FN];
        z = flags[FZ];
        c = flags[FC];
        v = flags[FV];
        unique case (code)
            CC_ZSET: pass = z;
            CC_ZCLR: pass = !z;
            CC_CSET: pass = c;
            CC_CCLR: pass = !c;
            CC_NSET: pass = n;
            CC_NCLR: pass = !n;
            CC_VSET: pass = v;
            CC_VCLR: pass = !v;
            CC_UGT:  pass = c && !z;
            CC_ULE:  pass = !c || z;
            CC_SGE:  pass = (n == v);
            CC_SLT:  pass = (n != v);
            CC_SGT:  pass = !z && (n == v);
            CC_SLE:  pass = z || (n != v);
            CC_ALL:  pass = 1'b1;
            CC_NONE: pass = 1'b0;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg
    import cfu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  flag_src_e          src,
    input  logic [FLAG_W-1:0]  alu_val,
    input  logic [FLAG_W-1:0]  wr_val,
    output logic [FLAG_W-1:0]  flags_q
);
    logic [FLAG_W-1:0] flags_d;

    always_comb begin
        unique case (src)
            SRC_HOLD:  flags_d = flags_q;
            SRC_ALU:   flags_d = alu_val;
            SRC_WRITE: flags_d = wr_val;
            default:   flags_d = flags_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cfu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_valid,
    input  logic [3:0]  cond_code,
    input  logic [3:0]  alu_flags,
    input  logic        set_flags,
    input  logic        cmp_class,
    input  logic        flag_wr_en,
    input  logic [3:0]  flag_wr_data,
    output logic        exec_en,
    output logic [3:0]  flags_q
);
    logic      pass;
    flag_src_e src;

    cfu_cond_eval u_eval (
        .code  (cond_e'(cond_code)),
        .flags (flags_q),
        .pass  (pass)
    );

    always_comb begin
        exec_en = instr_valid && pass;
        if (flag_wr_en)
            src = SRC_WRITE;
        else if (exec_en && (set_flags || cmp_class))
            src = SRC_ALU;
        else
            src = SRC_HOLD;
    end

    cfu_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src),
        .alu_val (alu_flags),
        .wr_val  (flag_wr_data),
        .flags_q (flags_q)
    );

    a_r6_s_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && set_flags && !flag_wr_en) |=> (flags_q == $past(alu_flags)));

    a_r7_cmp_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && cmp_class && !flag_wr_en) |=> (flags_q == $past(alu_flags)));

    a_r8_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !exec_en && !flag_wr_en) |=> $stable(flags_q));

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr_en |=> (flags_q == $past(flag_wr_data)));

    a_r5_never_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'hF) |-> !exec_en);

    a_r12_idle_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !exec_en);
endmodule

// File: tb/cond_flag_unit_tb_top.sv
module cond_flag_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       instr_valid;
    logic [3:0] cond_code;
    logic [3:0] alu_flags;
    logic       set_flags;
    logic       cmp_class;
    logic       flag_wr_en;
    logic [3:0] flag_wr_data;
    logic       exec_en;
    logic [3:0] flags_q;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int model_flags = 0;

    always #2.5 clk = ~clk;

    cond_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .cond_code(cond_code),
        .alu_flags(alu_flags), .set_flags(set_flags), .cmp_class(cmp_class),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .exec_en(exec_en), .flags_q(flags_q)
    );

    function automatic bit ref_pass(int code, int f);
        bit n = f[3], z = f[2], c = f[1], v = f[0];
        if (code == 15) return 0;
        if (code == 14) return 1;
        if (code >= 10) begin
            bit ge = (n == v);
            if (code == 10) return ge;
            if (code == 11) return !ge;
            if (code == 12) return ge && !z;
            return !ge || z;
        end
        if (code == 8) return c && !z;
        if (code == 9) return !(c && !z);
        case (code / 2)
            0: return (code % 2) ? !z : z;
            1: return (code % 2) ? !c : c;
            2: return (code % 2) ? !n : n;
            default: return (code % 2) ? !v : v;
        endcase
    endfunction

    function automatic string code_tag(int code);
        if (code < 8) return "R2";
        if (code < 10) return "R3";
        if (code < 14) return "R4";
        return "R5";
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive on falling edge, check exec_en before the rising edge, check flags after it
    task automatic slot(bit v, int cc, int alu, bit s, bit cmp, bit we, int wd,
                        string etag, string ftag);
        bit exp_exec;
        @(negedge clk);
        instr_valid = v; cond_code = cc[3:0]; alu_flags = alu[3:0];
        set_flags = s; cmp_class = cmp; flag_wr_en = we; flag_wr_data = wd[3:0];
        #1;
        exp_exec = v && ref_pass(cc, model_flags);
        check(etag, int'(exec_en), int'(exp_exec));
        @(posedge clk);
        if (we) model_flags = wd;
        else if (exp_exec && (s || cmp)) model_flags = alu;
        #1;
        check(ftag, int'(flags_q), model_flags);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; instr_valid = 0; cond_code = 0; alu_flags = 0;
        set_flags = 0; cmp_class = 0; flag_wr_en = 0; flag_wr_data = 0;
        repeat (3) @(negedge clk);
        check("R1", int'(flags_q), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", int'(flags_q), 0);

        // all codes against all flag states, flags loaded through the write port
        for (int f = 0; f < 16; f++) begin
            for (int cc = 0; cc < 16; cc++) begin
                slot(0, 0, 0, 0, 0, 1, f, "R12", "R10");
                slot(1, cc, 0, 0, 0, 0, 0, code_tag(cc), "R9");
            end
        end

        // R6: S update, R11: next instruction sees new flags
        slot(1, 14, 4'b0100, 1, 0, 0, 0, "R5", "R6");
        slot(1, 0, 4'b1000, 1, 0, 0, 0, "R11", "R6");
        slot(1, 0, 4'b0000, 1, 0, 0, 0, "R11", "R8");
        // R7: compare class latches without S
        slot(1, 14, 4'b1001, 0, 1, 0, 0, "R5", "R7");
        slot(1, 10, 4'b0011, 0, 1, 0, 0, "R11", "R7");
        // R8: never-code with S and compare keeps flags
        slot(1, 15, 4'b1111, 1, 1, 0, 0, "R5", "R8");
        // R12: idle slot ignores ALU
        slot(0, 14, 4'b1111, 1, 1, 0, 0, "R12", "R12");
        // R10: write port beats ALU update
        slot(1, 14, 4'b1111, 1, 1, 1, 4'b0110, "R5", "R10");
        slot(1, 14, 4'b0001, 0, 0, 0, 0, "R5", "R9");

        for (int i = 0; i < 3000; i++) begin
            int cc = $urandom_range(15);
            bit v = ($urandom_range(7) != 0);
            bit s = $urandom_range(1);
            bit cm = ($urandom_range(3) == 0);
            bit we = ($urandom_range(9) == 0);
            bit ep = v && ref_pass(cc, model_flags);
            string ft;
            if (we) ft = "R10";
            else if (!v) ft = "R12";
            else if (!ep) ft = "R8";
            else if (s) ft = "R6";
            else if (cm) ft = "R7";
            else ft = "R9";
            slot(v, cc, $urandom_range(15), s, cm, we, $urandom_range(15),
                 v ? code_tag(cc) : "R12", ft);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule